// File: doc/BRIEF.md
# UDP transmit packet engine

The engine takes a stream of 8-bit ADC samples, one byte per handshake, and turns every group of `N_SMP` samples into a finished IPv4/UDP datagram ready for an Ethernet MAC. It packs the samples four at a time into 32-bit words of a transmit buffer that has per-byte write enables. It also stamps the set with the time at which its first sample arrived. It then writes the IP and UDP headers around the payload and computes both checksums in hardware, so software does no checksum work on transmit. The ones'-complement sum of the payload is built up while the samples arrive. After the last sample only the header terms remain, so a datagram is ready ten cycles after its last sample.

There are two transmit buffers. One fills while the other drains to the MAC over a valid/ready word stream with a last-word marker. Addresses and ports are static configuration inputs. The payload length is fixed by a parameter.

The MAC can flag an error on a frame. If the other buffer is still filling, the frame is sent again from its first word. If the other buffer already holds a finished frame, waiting would stall the sample stream. In that case the failed frame is discarded, a one-cycle pulse is raised and a sticky flag is set. The receiver notices the gap from the jump in timestamps.

Top module: `udp_tx_engine`

## Requirements
- R1: Samples are packed four per 32-bit payload word, in arrival order, with the earliest sample in bits [31:24]. Payload words follow the header words in the frame.
- R2: A frame is 8 header words followed by `N_SMP/4` payload words. The header words, each big-endian within the word, are:
  - word 0 = {0x45, 0x00, total length = 32+N_SMP}
  - word 1 = 0x00004000
  - word 2 = {TTL=64, protocol 17, IP checksum}
  - word 3 = source IP
  - word 4 = destination IP
  - word 5 = {source port, destination port}
  - word 6 = {UDP length = 12+N_SMP, UDP checksum}
  - word 7 = timestamp
- R3: The IP checksum in word 2 bits [15:0] is the ones'-complement of the ones'-complement sum of header words 0 to 4, computed with that checksum field taken as zero.
- R4: The UDP checksum in word 6 bits [15:0] is the ones'-complement of the end-around-carry sum of the following terms: source IP, destination IP, protocol 17, UDP length, and words 5 to the end of the frame with the checksum field taken as zero. A result of 0x0000 is sent as 0xFFFF.
- R5: The timestamp is the value of `ts_in` in the cycle the set's first sample is accepted. Later changes to `ts_in` during the set have no effect.
- R6: `tx_data` and `tx_valid` hold steady while `tx_ready` is low. `tx_last` is high on the final word only.
- R7: While one frame waits at the MAC interface, the next set is accepted into the other buffer. When both buffers hold finished frames, `smp_ready` is low.
- R8: `tx_err` while `tx_valid` is high, with the other buffer not yet finished, restarts the frame from word 0. Nothing is dropped.
- R9: `tx_err` while `tx_valid` is high, with the other buffer holding a finished frame, discards the current frame. `drop_pulse` is then high for one cycle and `drop_flag` stays high until reset. The next frame sent is the following set.
- R10: After reset, `smp_ready` is 1 and `tx_valid`, `drop_pulse` and `drop_flag` are 0.
- R11: With the MAC side idle, `tx_valid` rises exactly 10 clock edges after the edge at which the last sample of a set is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample present |
| smp_data | input | 8 | ADC sample byte |
| smp_ready | output | 1 | Sample accepted when high with smp_valid |
| ts_in | input | 32 | Current time, latched at a set's first sample |
| src_ip | input | 32 | Source IPv4 address |
| dst_ip | input | 32 | Destination IPv4 address |
| src_port | input | 16 | UDP source port |
| dst_port | input | 16 | UDP destination port |
| tx_valid | output | 1 | Frame word present |
| tx_ready | input | 1 | MAC takes the word |
| tx_data | output | 32 | Frame word, first wire byte in [31:24] |
| tx_last | output | 1 | Final word of the frame |
| tx_err | input | 1 | MAC error on the current frame |
| drop_pulse | output | 1 | One-cycle pulse when a frame is discarded |
| drop_flag | output | 1 | Sticky discard indication, cleared by reset |

## Verification
The checksum corner the bench aims at is a UDP sum that folds to zero. The payload is built so the complement is exactly 0x0000; a design that skipped the substitution would send 0x0000, which a receiver reads as "no checksum". Stalled handshakes and a timestamp input that changes mid-set catch a design that lets data slip or latches the time late. The error tests run once with the other buffer still filling and once with it finished. A design that mixes up the two cases would either lose a frame it could have resent, or deadlock the sample stream behind a frame that keeps failing. Both frames of a ping-pong pair are checked word for word to catch writes into the wrong buffer.

// File: rtl/udp_tx_engine.sv
module udp_tx_engine #(
  parameter int N_SMP = 16,
  parameter int TTL   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [7:0]  smp_data,
  output logic        smp_ready,
  input  logic [31:0] ts_in,
  input  logic [31:0] src_ip,
  input  logic [31:0] dst_ip,
  input  logic [15:0] src_port,
  input  logic [15:0] dst_port,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic        tx_last,
  input  logic        tx_err,
  output logic        drop_pulse,
  output logic        drop_flag
);
  localparam int PAY_W   = N_SMP / 4;
  localparam int HDR_W   = 8;
  localparam int DEPTH   = HDR_W + PAY_W;
  localparam int AW      = $clog2(2 * DEPTH);
  localparam int IW      = $clog2(DEPTH);
  localparam int UDP_LEN = 12 + N_SMP;
  localparam int IP_LEN  = 20 + UDP_LEN;

  typedef enum logic [2:0] {COL, HDR, CK1, CK2, SWAP} fill_t;

  fill_t          st;
  logic           fill_sel, tx_sel;
  logic [1:0]     full;
  logic [1:0]     bcnt;
  logic [IW-1:0]  wcnt, tx_idx;
  logic [2:0]     hidx;
  logic [23:0]    sreg;
  logic [31:0]    ts_q, ip_acc, udp_acc, hword;
  logic [31:0]    mem [2*DEPTH];

  logic           we;
  logic [3:0]     wbe;
  logic [AW-1:0]  waddr, fbase, tbase;
  logic [31:0]    wdata, pword;
  logic [15:0]    ip_ck, udp_raw, udp_ck;
  logic           fire, drop_now;

  function automatic logic [15:0] fold(input logic [31:0] a);
    logic [16:0] s1, s2;
    s1 = {1'b0, a[31:16]} + {1'b0, a[15:0]};
    s2 = {1'b0, s1[15:0]} + {16'h0, s1[16]};
    return s2[15:0];
  endfunction

  assign smp_ready = (st == COL);
  assign fire      = smp_ready && smp_valid;
  assign pword     = {sreg, smp_data};
  assign fbase     = fill_sel ? AW'(DEPTH) : '0;
  assign tbase     = tx_sel   ? AW'(DEPTH) : '0;
  assign ip_ck     = ~fold(ip_acc);
  assign udp_raw   = ~fold(udp_acc);
  assign udp_ck    = (udp_raw == 16'h0) ? 16'hFFFF : udp_raw;

  assign tx_valid  = full[tx_sel];
  assign tx_data   = mem[tbase + AW'(tx_idx)];
  assign tx_last   = tx_valid && (tx_idx == IW'(DEPTH - 1));
  assign drop_now  = tx_valid && tx_err && full[~tx_sel];

  always_comb begin
    case (hidx)
      3'd0:    hword = {8'h45, 8'h00, 16'(IP_LEN)};
      3'd1:    hword = 32'h0000_4000;
      3'd2:    hword = {8'(TTL), 8'd17, 16'h0};
      3'd3:    hword = src_ip;
      3'd4:    hword = dst_ip;
      3'd5:    hword = {src_port, dst_port};
      3'd6:    hword = {16'(UDP_LEN), 16'h0};
      default: hword = ts_q;
    endcase
  end

  always_comb begin
    we = 1'b0; wbe = 4'h0; waddr = '0; wdata = '0;
    case (st)
      COL: if (fire && bcnt == 2'd3) begin
        we = 1'b1; wbe = 4'hF; wdata = pword;
        waddr = fbase + AW'(HDR_W) + AW'(wcnt);
      end
      HDR: begin
        we = 1'b1; wbe = 4'hF; wdata = hword;
        waddr = fbase + AW'(hidx);
      end
      CK1: begin
        we = 1'b1; wbe = 4'h3; wdata = {16'h0, ip_ck};
        waddr = fbase + AW'(2);
      end
      CK2: begin
        we = 1'b1; wbe = 4'h3; wdata = {16'h0, udp_ck};
        waddr = fbase + AW'(6);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (we)
      for (int b = 0; b < 4; b++)
        if (wbe[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= COL; fill_sel <= 1'b0; tx_sel <= 1'b0; full <= 2'b00;
      bcnt <= '0; wcnt <= '0; hidx <= '0; sreg <= '0; ts_q <= '0;
      ip_acc <= '0; udp_acc <= 32'(17 + UDP_LEN);
      tx_idx <= '0; drop_pulse <= 1'b0; drop_flag <= 1'b0;
    end else begin
      drop_pulse <= 1'b0;
      case (st)
        COL: if (fire) begin
          sreg <= {sreg[15:0], smp_data};
          bcnt <= bcnt + 2'd1;
          if (bcnt == 2'd0 && wcnt == '0) ts_q <= ts_in;
          if (bcnt == 2'd3) begin
            udp_acc <= udp_acc + {16'h0, pword[31:16]} + {16'h0, pword[15:0]};
            if (wcnt == IW'(PAY_W - 1)) begin
              st <= HDR; hidx <= '0;
            end else wcnt <= wcnt + 1'b1;
          end
        end
        HDR: begin
          if (hidx < 3'd5) ip_acc <= ip_acc + {16'h0, hword[31:16]} + {16'h0, hword[15:0]};
          if (hidx > 3'd2) udp_acc <= udp_acc + {16'h0, hword[31:16]} + {16'h0, hword[15:0]};
          hidx <= hidx + 3'd1;
          if (hidx == 3'd7) st <= CK1;
        end
        CK1: st <= CK2;
        CK2: begin
          full[fill_sel] <= 1'b1;
          st <= SWAP;
        end
        default: if (!full[~fill_sel]) begin
          fill_sel <= ~fill_sel; st <= COL;
          bcnt <= '0; wcnt <= '0; ip_acc <= '0;
          udp_acc <= 32'(17 + UDP_LEN);
        end
      endcase

      if (tx_valid) begin
        if (drop_now) begin
          full[tx_sel] <= 1'b0; tx_sel <= ~tx_sel; tx_idx <= '0;
          drop_pulse <= 1'b1; drop_flag <= 1'b1;
        end else if (tx_err) begin
          tx_idx <= '0;
        end else if (tx_ready) begin
          if (tx_last) begin
            full[tx_sel] <= 1'b0; tx_sel <= ~tx_sel; tx_idx <= '0;
          end else tx_idx <= tx_idx + 1'b1;
        end
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !tx_err |=> tx_valid && $stable(tx_data)); // R6
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !full[waddr >= AW'(DEPTH)]); // R7
  AST_READY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> !full[fill_sel]); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_err && !full[~tx_sel] |=> tx_valid && tx_idx == '0 && !drop_pulse); // R8
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(tx_valid && tx_err)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_flag |=> drop_flag); // R9
endmodule

// File: tb/test_udp_tx_engine.sv
module test_udp_tx_engine;
  localparam int N = 16;
  localparam int D = 8 + N / 4;
  localparam logic [31:0] SRC = 32'hC0A8_0A01, DST = 32'hC0A8_0A63;
  localparam logic [15:0] SP = 16'd5000, DP = 16'd6001;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, tx_ready = 0, tx_err = 0;
  logic [7:0] smp_data = 0;
  logic [31:0] ts_in = 0;
  logic smp_ready, tx_valid, tx_last, drop_pulse, drop_flag;
  logic [31:0] tx_data;

  int n_chk = 0, n_bad = 0, cyc = 0, last_acc = 0;
  logic [7:0]  pay [N];
  logic [31:0] rx [D];
  logic [31:0] ea [D];
  logic [31:0] eb [D];

  udp_tx_engine #(.N_SMP(N)) i_udp_tx_engine (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .ts_in(ts_in), .src_ip(SRC), .dst_ip(DST),
    .src_port(SP), .dst_port(DP), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_err(tx_err),
    .drop_pulse(drop_pulse), .drop_flag(drop_flag));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ofold(input logic [31:0] s);
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    return s[15:0];
  endfunction

  function automatic logic [15:0] udp_fold(input logic [31:0] e [D]);
    logic [31:0] u = 32'd17 + 32'(12 + N);
    for (int k = 3; k < D; k++) begin
      logic [31:0] w = (k == 6) ? {e[k][31:16], 16'h0} : e[k];
      u += {16'h0, w[31:16]} + {16'h0, w[15:0]};
    end
    return ofold(u);
  endfunction

  task automatic make_exp(input logic [31:0] ts, output logic [31:0] e [D]);
    logic [31:0] s = 0;
    logic [15:0] c;
    e[0] = {8'h45, 8'h00, 16'(32 + N)}; e[1] = 32'h0000_4000;
    e[2] = {8'd64, 8'd17, 16'h0}; e[3] = SRC; e[4] = DST;
    e[5] = {SP, DP}; e[6] = {16'(12 + N), 16'h0}; e[7] = ts;
    for (int w = 0; w < N / 4; w++)
      e[8 + w] = {pay[4*w], pay[4*w+1], pay[4*w+2], pay[4*w+3]};
    for (int k = 0; k < 5; k++) s += {16'h0, e[k][31:16]} + {16'h0, e[k][15:0]};
    e[2][15:0] = ~ofold(s);
    c = ~udp_fold(e);
    e[6][15:0] = (c == 16'h0) ? 16'hFFFF : c;
  endtask

  task automatic set_pay(input int seed);
    for (int i = 0; i < N; i++) pay[i] = 8'(seed * 7 + i * 13 + 1);
  endtask

  task automatic push_set(input logic [31:0] ts);
    for (int i = 0; i < N; i++) begin
      smp_valid = 1; smp_data = pay[i];
      ts_in = (i == 0) ? ts : ts + 32'd100;
      while (!smp_ready) @(negedge clk);
      if (i == N - 1) last_acc = cyc + 1;
      @(negedge clk);
    end
    smp_valid = 0;
  endtask

  task automatic recv(input bit stall);
    int k = 0, g = 0;
    bit held = 0;
    logic [31:0] hd = 0;
    while (k < D && g < 500) begin
      if (held) begin
        chk("R6 hold valid", {31'h0, tx_valid}, 32'd1);
        chk("R6 hold data", tx_data, hd);
      end
      tx_ready = stall ? ((g % 3) != 0) : 1'b1;
      held = tx_valid && !tx_ready;
      hd = tx_data;
      if (tx_valid && tx_ready) begin
        rx[k] = tx_data;
        chk("R6 last marker", {31'h0, tx_last}, {31'h0, (k == D - 1)});
        k++;
      end
      g++;
      @(negedge clk);
    end
    tx_ready = 0;
    chk("R6 frame length", 32'(k), 32'(D));
  endtask

  task automatic cmp_frame(input string req, input logic [31:0] e [D]);
    for (int k = 0; k < D; k++) chk(req, rx[k], e[k]);
  endtask

  task automatic t_reset;
    chk("R10 smp_ready", {31'h0, smp_ready}, 32'd1);
    chk("R10 tx_valid", {31'h0, tx_valid}, 32'd0);
    chk("R10 drop_pulse", {31'h0, drop_pulse}, 32'd0);
    chk("R10 drop_flag", {31'h0, drop_flag}, 32'd0);
  endtask

  task automatic t_basic;
    set_pay(1); make_exp(32'h1122_3344, ea);
    push_set(32'h1122_3344);
    while (!tx_valid) @(negedge clk);
    chk("R11 header latency", 32'(cyc - last_acc), 32'd10);
    recv(0);
    cmp_frame("R1 R2 R3 R4 R5 basic frame", ea);
    chk("R5 timestamp word", rx[7], 32'h1122_3344);
    chk("R1 first payload word", rx[8], {pay[0], pay[1], pay[2], pay[3]});
  endtask

  task automatic t_stall;
    set_pay(5); make_exp(32'hA5A5_0001, ea);
    push_set(32'hA5A5_0001);
    recv(1);
    cmp_frame("R6 stalled frame", ea);
  endtask

  task automatic t_zero;
    logic [15:0] s;
    set_pay(9); pay[N-2] = 0; pay[N-1] = 0;
    make_exp(32'h0000_7777, ea);
    s = udp_fold(ea);
    {pay[N-2], pay[N-1]} = ~s;
    make_exp(32'h0000_7777, ea);
    push_set(32'h0000_7777);
    recv(0);
    chk("R4 zero sum sent as FFFF", {16'h0, rx[6][15:0]}, 32'h0000_FFFF);
    cmp_frame("R4 zero case frame", ea);
  endtask

  task automatic t_pingpong;
    set_pay(3); make_exp(32'h0000_0100, ea); push_set(32'h0000_0100);
    repeat (12) @(negedge clk);
    chk("R7 second set accepted while first waits", {30'h0, tx_valid, smp_ready}, 32'd3);
    set_pay(4); make_exp(32'h0000_0200, eb); push_set(32'h0000_0200);
    repeat (12) @(negedge clk);
    chk("R7 both full blocks samples", {31'h0, smp_ready}, 32'd0);
    recv(0); cmp_frame("R7 first of pair", ea);
    recv(0); cmp_frame("R7 second of pair", eb);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_retry;
    set_pay(6); make_exp(32'h0000_0300, ea); push_set(32'h0000_0300);
    while (!tx_valid) @(negedge clk);
    tx_ready = 1;
    repeat (3) @(negedge clk);
    tx_err = 1; @(negedge clk); tx_err = 0; tx_ready = 0;
    chk("R8 no drop pulse", {31'h0, drop_pulse}, 32'd0);
    chk("R8 frame still offered", {31'h0, tx_valid}, 32'd1);
    recv(0);
    cmp_frame("R8 resent from word 0", ea);
    chk("R8 drop flag clear", {31'h0, drop_flag}, 32'd0);
  endtask

  task automatic t_drop;
    set_pay(7); make_exp(32'h0000_0400, ea); push_set(32'h0000_0400);
    set_pay(8); make_exp(32'h0000_0500, eb); push_set(32'h0000_0500);
    repeat (12) @(negedge clk);
    tx_err = 1; @(negedge clk); tx_err = 0;
    chk("R9 drop pulse", {31'h0, drop_pulse}, 32'd1);
    chk("R9 drop flag", {31'h0, drop_flag}, 32'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, drop_pulse}, 32'd0);
    chk("R9 flag sticky", {31'h0, drop_flag}, 32'd1);
    recv(0);
    cmp_frame("R9 next set follows", eb);
    repeat (3) @(negedge clk);
    chk("R9 samples flow again", {31'h0, smp_ready}, 32'd1);
    chk("R9 nothing else pending", {31'h0, tx_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_stall;
    t_zero;
    t_pingpong;
    t_retry;
    t_drop;
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule